// File: doc/BRIEF.md
# Oscillator Trim Synchronization Controller

This block produces a 5-bit trim code for an on-chip oscillator. Its aim is to keep the local clock in step with a master node on a shared bus. The master sends heartbeat frames about every 100 ms and sync frames about every 1000 ms. The block sees only three one-cycle strobes: a local millisecond tick, a heartbeat-received pulse and a sync-received pulse. Decoding the frames, the oscillator and the tick divider all sit outside the block.

The block has three modes.

- **Coarse search.** After reset the block hops the trim code on alternating sides of a centre value in steps of 2, until any heartbeat is received.
- **Fine search.** The block then centres on the code in use when that heartbeat arrived. It hops around that centre in steps of 1 at half the rate, until three closely spaced heartbeats arrive.
- **Tracking.** The block counts ticks between sync frames and adjusts the trim by one code when the count drifts from 1000 by more than a learned deadband. The deadband is the change in count that its own last adjustment produced. If two sync intervals pass with no sync frame, the block drops back to coarse search.

Top module: `osc_trim_sync`

## Requirements
- R1: After reset, `trim_code` is 16 and `sync_state` is 0. `sync_state` encodes coarse search = 0, fine search = 1 and tracking = 2, and never shows 3.
- R2: In coarse search the code visits, in order, the centre, then centre-2, centre+2, centre-4, centre+4 and so on. For a centre of 16 this gives 16, 14, 18, 12, ... Each value is held for 250 ticks. Values outside 0..31 are skipped. When both sides are used up, the code returns to the centre.
- R3: While searching, the trim code never changes unless a tick arrives. With no ticks it holds its value indefinitely.
- R4: A heartbeat in coarse search moves the block to fine search on the next clock. The trim code in use becomes the fine-search centre and is left unchanged.
- R5: In fine search the code follows the same alternating order with a step of 1, and each value is held for 500 ticks.
- R6: Fine search ends and tracking begins on the third consecutive heartbeat. If more than 150 ticks pass after a heartbeat with no further heartbeat, the consecutive count returns to zero.
- R7: In tracking, the first sync frame (after entry, or after a miss) only starts the interval. At each later sync frame, the measured tick count M is compared with 1000:
  - if M - 1000 exceeds the deadband, the code is decremented (floor 0);
  - if 1000 - M exceeds the deadband, the code is incremented (ceiling 31);
  - otherwise the code stays the same.
- R8: The deadband is 3 on entry to tracking. For the measurement that follows a trim change, the deadband becomes |M - M_prev|, where M_prev is the measurement that caused the change. That new value already applies to the decision on that same measurement.
- R9: A run of 1500 ticks without a sync frame counts as one miss and restarts the interval, so the next sync frame only restarts counting. A sync frame clears the miss count. On a second consecutive miss, the block returns to coarse search, centred on the current code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| tick_ms | input | 1 | One-cycle strobe every local millisecond |
| hb_pulse | input | 1 | One-cycle strobe per received heartbeat frame |
| sync_pulse | input | 1 | One-cycle strobe per received sync frame |
| trim_code | output | 5 | Oscillator trim code |
| sync_state | output | 2 | Current mode: 0 coarse, 1 fine, 2 tracking |

## Verification
The bench runs coarse search through a full cycle of the alternating order, including the point where the upper side overruns 31 and the order wraps back to the centre. A design with wrong skip or wrap logic would emit an out-of-range or out-of-order code at that point.

It inserts a 200-tick heartbeat gap during fine search. A design that does not clear the consecutive count would enter tracking 200 ticks early.

In tracking, a measurement of 1004 ticks follows a trim change. This count lies outside the initial deadband but inside the learned one, so a design that ignores the learned value would trim again.

A 1600-tick sync gap and a 3000-tick silence check the miss rules. A design that does not restart the interval would apply a bogus correction after the 1600-tick gap. One that ignores misses would stay in tracking through the silence.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    ST_COARSE = 2'd0,
    ST_FINE   = 2'd1,
    ST_TRACK  = 2'd2
  } ot_state_e;
endpackage

// File: rtl/otr_search_gen.sv
// Alternating search order around a centre: k=0 centre, odd k below, even k above.
// Returns the next in-range entry after idx, or wraps to the centre.
module otr_search_gen #(
  parameter int TRIM_W = 5,
  parameter int IDX_W  = 7,
  parameter int STEP   = 2
) (
  input  logic [TRIM_W-1:0] centre,
  input  logic [IDX_W-1:0]  idx,
  output logic [IDX_W-1:0]  nxt_idx,
  output logic [TRIM_W-1:0] nxt_val
);
  localparam int VW = TRIM_W + IDX_W + 2;
  localparam logic signed [VW-1:0] STEP_S = VW'(STEP);
  localparam logic signed [VW-1:0] TOP_S  = VW'((1 << TRIM_W) - 1);

  function automatic logic signed [VW-1:0] cand(input logic [TRIM_W-1:0] c,
                                                input logic [IDX_W-1:0]  k);
    logic signed [VW-1:0] base;
    logic signed [VW-1:0] off;
    base = signed'(VW'(c));
    off  = signed'(VW'(({1'b0, k} + 1'b1) >> 1)) * STEP_S;
    if (k == '0)   cand = base;
    else if (k[0]) cand = base - off;
    else           cand = base + off;
  endfunction

  function automatic logic fits(input logic signed [VW-1:0] v);
    fits = !v[VW-1] && (v <= TOP_S);
  endfunction

  logic [IDX_W-1:0]     k1, k2;
  logic signed [VW-1:0] v1, v2;

  always_comb begin
    k1 = idx + 1'b1;
    k2 = idx + 2'd2;
    v1 = cand(centre, k1);
    v2 = cand(centre, k2);
    if (fits(v1)) begin
      nxt_idx = k1;
      nxt_val = v1[TRIM_W-1:0];
    end else if (fits(v2)) begin
      nxt_idx = k2;
      nxt_val = v2[TRIM_W-1:0];
    end else begin
      nxt_idx = '0;
      nxt_val = centre;
    end
  end
endmodule

// File: rtl/otr_track_eval.sv
// Tracking decision for one closed sync interval.
module otr_track_eval #(
  parameter int TRIM_W = 5,
  parameter int CNT_W  = 11,
  parameter int TARGET = 1000
) (
  input  logic [CNT_W-1:0]  meas,
  input  logic [CNT_W-1:0]  prev,
  input  logic              pend,
  input  logic [CNT_W-1:0]  delta,
  input  logic [TRIM_W-1:0] trim,
  output logic [TRIM_W-1:0] trim_nxt,
  output logic              stepped,
  output logic [CNT_W-1:0]  delta_nxt
);
  localparam int SW = CNT_W + 1;

  logic signed [SW-1:0] err, chg;
  logic [CNT_W-1:0]     abs_err, abs_chg;
  logic                 fast, slow;

  always_comb begin
    err     = signed'({1'b0, meas}) - signed'(SW'(TARGET));
    chg     = signed'({1'b0, meas}) - signed'({1'b0, prev});
    abs_err = err[SW-1] ? CNT_W'(-err) : err[CNT_W-1:0];
    abs_chg = chg[SW-1] ? CNT_W'(-chg) : chg[CNT_W-1:0];
    delta_nxt = pend ? abs_chg : delta;
    fast = !err[SW-1] && (abs_err > delta_nxt);
    slow = err[SW-1] && (abs_err > delta_nxt);
    trim_nxt = trim;
    stepped  = 1'b0;
    if (fast && (trim != '0)) begin
      trim_nxt = trim - 1'b1;
      stepped  = 1'b1;
    end else if (slow && (trim != '1)) begin
      trim_nxt = trim + 1'b1;
      stepped  = 1'b1;
    end
  end
endmodule

// File: rtl/osc_trim_sync.sv
// rst_n is expected to be released synchronously to clk by the reset tree.
module osc_trim_sync
  import osc_trim_pkg::*;
#(
  parameter int TRIM_W       = 5,
  parameter int TRIM_RST     = 16,
  parameter int COARSE_STEP  = 2,
  parameter int FINE_STEP    = 1,
  parameter int COARSE_DWELL = 250,
  parameter int FINE_DWELL   = 500,
  parameter int HB_GAP_MAX   = 150,
  parameter int HB_NEEDED    = 3,
  parameter int SYNC_TARGET  = 1000,
  parameter int SYNC_TIMEOUT = 1500,
  parameter int MISS_LIMIT   = 2,
  parameter int DELTA_INIT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              hb_pulse,
  input  logic              sync_pulse,
  output logic [TRIM_W-1:0] trim_code,
  output logic [1:0]        sync_state
);
  localparam int IDX_W  = TRIM_W + 2;
  localparam int DWMAX  = (COARSE_DWELL > FINE_DWELL) ? COARSE_DWELL : FINE_DWELL;
  localparam int DW_W   = $clog2(DWMAX + 1);
  localparam int CNT_W  = $clog2(SYNC_TIMEOUT + 1);
  localparam int GAP_W  = $clog2(HB_GAP_MAX + 2);
  localparam int HBC_W  = $clog2(HB_NEEDED + 1);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  ot_state_e         state_q, state_d;
  logic [TRIM_W-1:0] trim_q, trim_d, centre_q, centre_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DW_W-1:0]   dwell_q, dwell_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [HBC_W-1:0]  hbc_q, hbc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, prev_q, prev_d, delta_q, delta_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              first_q, first_d, pend_q, pend_d;

  logic [IDX_W-1:0]  c_idx, f_idx;
  logic [TRIM_W-1:0] c_val, f_val, t_trim;
  logic [CNT_W-1:0]  meas, t_delta;
  logic              t_step;

  otr_search_gen #(.TRIM_W(TRIM_W), .IDX_W(IDX_W), .STEP(COARSE_STEP)) u_coarse (
    .centre(centre_q), .idx(idx_q), .nxt_idx(c_idx), .nxt_val(c_val));

  otr_search_gen #(.TRIM_W(TRIM_W), .IDX_W(IDX_W), .STEP(FINE_STEP)) u_fine (
    .centre(centre_q), .idx(idx_q), .nxt_idx(f_idx), .nxt_val(f_val));

  assign meas = cnt_q + CNT_W'(tick_ms);

  otr_track_eval #(.TRIM_W(TRIM_W), .CNT_W(CNT_W), .TARGET(SYNC_TARGET)) u_eval (
    .meas(meas), .prev(prev_q), .pend(pend_q), .delta(delta_q), .trim(trim_q),
    .trim_nxt(t_trim), .stepped(t_step), .delta_nxt(t_delta));

  // Next-state logic
  always_comb begin
    state_d = state_q; trim_d = trim_q; centre_d = centre_q; idx_d = idx_q;
    dwell_d = dwell_q; gap_d = gap_q; hbc_d = hbc_q; cnt_d = cnt_q;
    prev_d = prev_q; delta_d = delta_q; miss_d = miss_q;
    first_d = first_q; pend_d = pend_q;
    case (state_q)
      ST_COARSE: begin
        if (hb_pulse) begin
          state_d = ST_FINE; centre_d = trim_q; idx_d = '0;
          dwell_d = '0; gap_d = '0; hbc_d = '0;
        end else if (tick_ms) begin
          if (dwell_q == DW_W'(COARSE_DWELL - 1)) begin
            idx_d = c_idx; trim_d = c_val; dwell_d = '0;
          end else begin
            dwell_d = dwell_q + 1'b1;
          end
        end
      end
      ST_FINE: begin
        if (hb_pulse && (hbc_q == HBC_W'(HB_NEEDED - 1))) begin
          state_d = ST_TRACK; cnt_d = '0; first_d = 1'b0; miss_d = '0;
          pend_d = 1'b0; delta_d = CNT_W'(DELTA_INIT);
        end else begin
          if (tick_ms) begin
            if (dwell_q == DW_W'(FINE_DWELL - 1)) begin
              idx_d = f_idx; trim_d = f_val; dwell_d = '0;
            end else begin
              dwell_d = dwell_q + 1'b1;
            end
          end
          if (hb_pulse) begin
            hbc_d = hbc_q + 1'b1; gap_d = '0;
          end else if (tick_ms && (gap_q <= GAP_W'(HB_GAP_MAX))) begin
            gap_d = gap_q + 1'b1;
            if (gap_q == GAP_W'(HB_GAP_MAX)) hbc_d = '0;
          end
        end
      end
      ST_TRACK: begin
        if (sync_pulse) begin
          miss_d = '0; cnt_d = '0;
          if (!first_q) begin
            first_d = 1'b1;
          end else begin
            delta_d = t_delta;
            pend_d  = t_step;
            if (t_step) begin
              trim_d = t_trim; prev_d = meas;
            end
          end
        end else if (tick_ms) begin
          if (cnt_q == CNT_W'(SYNC_TIMEOUT - 1)) begin
            cnt_d = '0; first_d = 1'b0;
            if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
              state_d = ST_COARSE; centre_d = trim_q; idx_d = '0;
              dwell_d = '0; miss_d = '0;
            end else begin
              miss_d = miss_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_COARSE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COARSE; trim_q <= TRIM_W'(TRIM_RST); centre_q <= TRIM_W'(TRIM_RST);
      idx_q <= '0; dwell_q <= '0; gap_q <= '0; hbc_q <= '0; cnt_q <= '0;
      prev_q <= '0; delta_q <= CNT_W'(DELTA_INIT); miss_q <= '0;
      first_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      state_q <= state_d; trim_q <= trim_d; centre_q <= centre_d;
      idx_q <= idx_d; dwell_q <= dwell_d; gap_q <= gap_d; hbc_q <= hbc_d;
      cnt_q <= cnt_d; prev_q <= prev_d; delta_q <= delta_d; miss_q <= miss_d;
      first_q <= first_d; pend_q <= pend_d;
    end
  end

  assign trim_code  = trim_q;
  assign sync_state = state_q;
endmodule

// File: rtl/otr_sync_chk.sv
module otr_sync_chk #(
  parameter int TRIM_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_ms,
  input logic              hb_pulse,
  input logic              sync_pulse,
  input logic [TRIM_W-1:0] trim_code,
  input logic [1:0]        sync_state
);
  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sync_state != 2'd3);  // R1

  AST_SEARCH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(sync_state) != 2'd2 && sync_state == $past(sync_state) &&
     trim_code != $past(trim_code)) |-> $past(tick_ms));  // R3

  AST_COARSE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(sync_state) == 2'd0 && sync_state != 2'd0) |->
    (sync_state == 2'd1 && $past(hb_pulse)));  // R4

  AST_FINE_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(sync_state) == 2'd0 && sync_state == 2'd1) |-> $stable(trim_code));  // R4

  AST_TRACK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(sync_state) != 2'd2 && sync_state == 2'd2) |->
    ($past(sync_state) == 2'd1 && $past(hb_pulse)));  // R6

  AST_TRACK_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(sync_state) == 2'd2 && sync_state == 2'd2) |->
    (trim_code == $past(trim_code) || trim_code == $past(trim_code) + 1'b1 ||
     trim_code == $past(trim_code) - 1'b1));  // R7

  AST_TRACK_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(sync_state) == 2'd2 && sync_state == 2'd2 &&
     trim_code != $past(trim_code)) |-> $past(sync_pulse));  // R7

  AST_TRACK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(sync_state) == 2'd2 && sync_state != 2'd2) |->
    (sync_state == 2'd0 && $past(tick_ms) && !$past(sync_pulse)));  // R9
endmodule

bind osc_trim_sync otr_sync_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .hb_pulse(hb_pulse),
  .sync_pulse(sync_pulse), .trim_code(trim_code), .sync_state(sync_state));

// File: tb/sim_osc_trim_sync.sv
module sim_osc_trim_sync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b0, hb_pulse = 1'b0, sync_pulse = 1'b0;
  logic [4:0] trim_code;
  logic [1:0] sync_state;

  always #4 clk = ~clk;  // 125 MHz

  osc_trim_sync u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .hb_pulse(hb_pulse),
    .sync_pulse(sync_pulse), .trim_code(trim_code), .sync_state(sync_state));

  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Behavioural reference model
  int seq[$];
  int m_mode, m_trim, m_pos, m_dwell, m_gap, m_hbc;
  int m_cnt, m_first, m_miss, m_prev, m_pend, m_delta;

  function automatic void build_seq(int c, int step);
    seq.delete();
    for (int k = 0; k <= 70; k++) begin
      int v;
      if (k == 0)      v = c;
      else if (k % 2)  v = c - ((k + 1) / 2) * step;
      else             v = c + (k / 2) * step;
      if (v >= 0 && v <= 31) seq.push_back(v);
    end
  endfunction

  function automatic void m_reset();
    m_mode = 0; m_trim = 16; build_seq(16, 2); m_pos = 0; m_dwell = 0;
    m_gap = 0; m_hbc = 0; m_cnt = 0; m_first = 0; m_miss = 0;
    m_prev = 0; m_pend = 0; m_delta = 3;
  endfunction

  function automatic void m_step(bit tk, bit hb, bit sy);
    int meas, err, eff;
    case (m_mode)
      0: begin
        if (hb) begin
          m_mode = 1; build_seq(m_trim, 1); m_pos = 0; m_dwell = 0; m_gap = 0; m_hbc = 0;
        end else if (tk) begin
          if (m_dwell == 249) begin
            m_pos = (m_pos + 1) % seq.size(); m_trim = seq[m_pos]; m_dwell = 0;
          end else m_dwell++;
        end
      end
      1: begin
        if (hb && m_hbc == 2) begin
          m_mode = 2; m_cnt = 0; m_first = 0; m_miss = 0; m_pend = 0; m_delta = 3;
        end else begin
          if (tk) begin
            if (m_dwell == 499) begin
              m_pos = (m_pos + 1) % seq.size(); m_trim = seq[m_pos]; m_dwell = 0;
            end else m_dwell++;
          end
          if (hb) begin
            m_hbc++; m_gap = 0;
          end else if (tk && m_gap <= 150) begin
            if (m_gap == 150) m_hbc = 0;
            m_gap++;
          end
        end
      end
      default: begin
        if (sy) begin
          m_miss = 0;
          if (!m_first) m_first = 1;
          else begin
            meas = m_cnt + int'(tk);
            err  = meas - 1000;
            if (m_pend) eff = (meas > m_prev) ? meas - m_prev : m_prev - meas;
            else        eff = m_delta;
            m_delta = eff; m_pend = 0;
            if (err > eff && m_trim > 0) begin
              m_trim--; m_pend = 1; m_prev = meas;
            end else if (-err > eff && m_trim < 31) begin
              m_trim++; m_pend = 1; m_prev = meas;
            end
          end
          m_cnt = 0;
        end else if (tk) begin
          if (m_cnt == 1499) begin
            m_cnt = 0; m_first = 0;
            if (m_miss == 1) begin
              m_mode = 0; build_seq(m_trim, 2); m_pos = 0; m_dwell = 0; m_miss = 0;
            end else m_miss++;
          end else m_cnt++;
        end
      end
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else        m_step(tick_ms, hb_pulse, sync_pulse);
    #2;
    if (rst_n && !done) begin
      chk({cur_req, " trim"}, int'(trim_code), m_trim);
      chk({cur_req, " state"}, int'(sync_state), m_mode);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_ms = 0; hb_pulse = 0; sync_pulse = 0;
    end
  endtask

  task automatic step_tick(bit hb, bit sy);
    @(negedge clk); tick_ms = 1; hb_pulse = 0; sync_pulse = 0;
    @(negedge clk); tick_ms = 0; hb_pulse = hb; sync_pulse = sy;
  endtask

  task automatic sync_after(int n);
    for (int i = 1; i < n; i++) step_tick(0, 0);
    step_tick(0, 1);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset trim", int'(trim_code), 16);
    chk("R1 reset state", int'(sync_state), 0);

    cur_req = "R3";
    idle(600);
    chk("R3 no tick hold", int'(trim_code), 16);

    cur_req = "R2";
    for (int t = 1; t <= 4600; t++) begin
      step_tick(0, 0);
      if (t == 250)  chk("R2 first hop", int'(trim_code), 14);
      if (t == 750)  chk("R2 third hop", int'(trim_code), 12);
      if (t == 3750) chk("R2 lower end", int'(trim_code), 0);
      if (t == 4000) chk("R2 wrap to centre", int'(trim_code), 16);
      if (t == 4600) chk("R2 after wrap", int'(trim_code), 18);
    end

    cur_req = "R4";
    step_tick(1, 0);
    idle(1);
    chk("R4 fine entered", int'(sync_state), 1);
    chk("R4 trim kept", int'(trim_code), 18);

    cur_req = "R6";
    for (int t = 1; t <= 600; t++) begin
      step_tick((t % 100 == 0) && (t != 300), 0);
      if (t == 400) begin
        idle(1);
        chk("R6 gap cleared count", int'(sync_state), 1);
      end
      if (t == 450) chk("R5 fine dwell hold", int'(trim_code), 18);
      if (t == 550) chk("R5 fine first hop", int'(trim_code), 17);
    end
    idle(1);
    chk("R6 tracking entered", int'(sync_state), 2);
    chk("R6 trim kept", int'(trim_code), 17);

    cur_req = "R7";
    sync_after(50);
    chk("R7 first sync no trim", int'(trim_code), 17);
    sync_after(1010);
    chk("R7 fast decrement", int'(trim_code), 16);

    cur_req = "R8";
    sync_after(1004);
    chk("R8 learned deadband holds", int'(trim_code), 16);
    sync_after(990);
    chk("R8 slow increment", int'(trim_code), 17);
    sync_after(998);
    chk("R8 within deadband", int'(trim_code), 17);
    sync_after(1002);
    chk("R8 within deadband 2", int'(trim_code), 17);

    cur_req = "R9";
    sync_after(1600);
    chk("R9 sync after miss only restarts", int'(trim_code), 17);
    chk("R9 single miss stays tracking", int'(sync_state), 2);
    sync_after(1000);
    chk("R9 on target", int'(trim_code), 17);
    for (int t = 1; t <= 3250; t++) begin
      step_tick(0, 0);
      if (t == 2999) chk("R9 still tracking", int'(sync_state), 2);
      if (t == 3000) begin
        chk("R9 back to coarse", int'(sync_state), 0);
        chk("R9 centre kept", int'(trim_code), 17);
      end
    end
    chk("R9 coarse around new centre", int'(trim_code), 15);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule